// File: doc/BRIEF.md
# Mirrored Frame Store Address Generator

This block turns a stream of captured video bytes into memory write addresses. Software-side setup supplies a buffer base address, the frame width and height in pixels, a layout select (packed 4:2:2 or three-plane 4:2:0), a chroma plane order select, and two mirror flags. From these the block derives the line strides, the origin of each plane and the first address written in each plane. It then tags every incoming byte with the plane it belongs to and the byte address where it must land, so that the stored picture is flipped left-to-right, upside-down, both or neither.

The capture front end delivers bytes in the order U, Y, V, Y, one byte per valid beat, with a padded pixel when the width is odd. In packed layout every byte is stored in sequence. In planar layout the luma bytes go to the Y plane, and the chroma bytes of even lines go to the U and V planes, while chroma bytes of odd lines are dropped. A one-cycle start pulse arms a frame. The block then follows lines and bytes until the last byte of the last line, and pulses a done flag.

Top module: `flip_frame_addr_gen`

## Requirements
- R1: In packed layout (`planar`=0) the luma stride is the width rounded up to even, times 2. `stride_chroma` is 0, `chroma_stride_flag` is 0, and all four U/V address outputs are 0.
- R2: In planar layout (`planar`=1) the luma stride is the width rounded up to a multiple of 8. `stride_chroma` is half of it and `chroma_stride_flag` is 1.
- R3: `y_base` equals `base_addr`. In planar layout with `yvu_order`=0, `u_base` = base + S·H and `v_base` = `u_base` + S·H/4, where S is the luma stride and H the height. With `yvu_order`=1 these two plane origins are exchanged.
- R4: The start address of a plane is its base plus the mirror offsets. `vflip` adds S·(H−1) to luma and (S/2)·(H/2−1) to each chroma plane. `hflip` adds S−1 to luma and S/2−1 to each chroma plane.
- R5: In packed layout, byte b of line L (both counted from 0, 2·roundup2(W) bytes per line) is written one cycle after it is accepted, with `wr_plane`=0. Its address is base + row·S + col, where row = H−1−L when `vflip` is set and L otherwise, and col = S−1−b when `hflip` is set and b otherwise.
- R6: In planar layout, bytes with b odd are luma (`wr_plane`=0) with luma index j=b/2. Their address is base + row·S + (S−1−j when `hflip`, else j).
- R7: In planar layout, bytes with b mod 4 = 0 are U (`wr_plane`=1) and b mod 4 = 2 are V (`wr_plane`=2), with chroma index c=b/4. They are written only on even lines, at plane origin + crow·(S/2) + (S/2−1−c when `hflip`, else c), where crow = H/2−1−L/2 when `vflip` is set and L/2 otherwise. On odd lines `wr_valid` stays low for them.
- R8: A cycle with `in_valid` low produces no write on the next cycle and does not advance the byte position.
- R9: The last byte of line H−1 raises `frame_done` for one cycle and drops `busy`. Later beats produce no write until the next `start`.
- R10: `start` while a frame is in progress abandons it and restarts at line 0, byte 0. A beat in the same cycle as `start` is ignored.
- R11: After reset `busy`, `wr_valid` and `frame_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Arms a new frame |
| base_addr | input | AW | Buffer base byte address |
| width | input | DW | Frame width in pixels |
| height | input | DW | Frame height in lines |
| planar | input | 1 | 1: three-plane 4:2:0, 0: packed 4:2:2 |
| yvu_order | input | 1 | Exchange the U and V plane locations |
| hflip | input | 1 | Mirror left-to-right |
| vflip | input | 1 | Mirror top-to-bottom |
| in_valid | input | 1 | One captured byte this cycle |
| busy | output | 1 | Frame in progress |
| wr_valid | output | 1 | Write strobe |
| wr_addr | output | AW | Byte address of the write |
| wr_plane | output | 2 | 0 luma/packed, 1 U, 2 V |
| frame_done | output | 1 | Last byte of the frame accepted |
| stride_luma | output | DW+2 | Luma (or packed) line stride in bytes |
| stride_chroma | output | DW+2 | Chroma line stride, 0 in packed layout |
| chroma_stride_flag | output | 1 | Set in planar layout |
| y_base | output | AW | Luma plane origin |
| y_start | output | AW | First luma address with mirroring |
| u_base | output | AW | U plane origin |
| u_start | output | AW | First U address with mirroring |
| v_base | output | AW | V plane origin |
| v_start | output | AW | First V address with mirroring |

## Verification
The hardest case to reach is chroma of a mirrored planar frame. The chroma row pointer moves only once per two lines, and on odd lines the chroma beats must vanish while the luma position keeps advancing. The stimulus streams whole planar frames with both flips, in both plane orders, with idle gaps between beats. Every beat is compared against an address computed from the row and column formulas and not from a running pointer. A drift of one stride or one byte in either direction therefore shows up at the first wrong byte.

// File: rtl/flip_frame_addr_gen.sv
module flip_frame_addr_gen #(
  parameter int AW = 32,
  parameter int DW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    base_addr,
  input  logic [DW-1:0]    width,
  input  logic [DW-1:0]    height,
  input  logic             planar,
  input  logic             yvu_order,
  input  logic             hflip,
  input  logic             vflip,
  input  logic             in_valid,
  output logic             busy,
  output logic             wr_valid,
  output logic [AW-1:0]    wr_addr,
  output logic [1:0]       wr_plane,
  output logic             frame_done,
  output logic [DW+1:0]    stride_luma,
  output logic [DW+1:0]    stride_chroma,
  output logic             chroma_stride_flag,
  output logic [AW-1:0]    y_base,
  output logic [AW-1:0]    y_start,
  output logic [AW-1:0]    u_base,
  output logic [AW-1:0]    u_start,
  output logic [AW-1:0]    v_base,
  output logic [AW-1:0]    v_start
);
  localparam int SW = DW + 2;

  logic [DW:0]   w_p1, w_p7, w_r2, w_r8;
  logic [SW-1:0] line_bytes, cs_i;
  logic [AW-1:0] sl_a, cs_a, h_a, hh_a, area, quarter, off_u, off_v, y_flip, c_flip;

  assign w_p1 = {1'b0, width} + (DW+1)'(1);
  assign w_p7 = {1'b0, width} + (DW+1)'(7);
  assign w_r2 = {w_p1[DW:1], 1'b0};
  assign w_r8 = {w_p7[DW:3], 3'b000};
  assign line_bytes = {w_r2, 1'b0};

  assign stride_luma        = planar ? {1'b0, w_r8} : line_bytes;
  assign cs_i               = {1'b0, stride_luma[SW-1:1]};
  assign stride_chroma      = planar ? cs_i : '0;
  assign chroma_stride_flag = planar;

  assign sl_a    = AW'(stride_luma);
  assign cs_a    = AW'(cs_i);
  assign h_a     = AW'(height);
  assign hh_a    = AW'(height[DW-1:1]);
  assign area    = sl_a * h_a;
  assign quarter = area >> 2;
  assign off_u   = yvu_order ? area + quarter : area;
  assign off_v   = yvu_order ? area : area + quarter;

  assign y_flip = (vflip ? sl_a * (h_a - AW'(1)) : '0) + (hflip ? sl_a - AW'(1) : '0);
  assign c_flip = (vflip ? cs_a * (hh_a - AW'(1)) : '0) + (hflip ? cs_a - AW'(1) : '0);

  assign y_base  = base_addr;
  assign y_start = base_addr + y_flip;
  assign u_base  = planar ? base_addr + off_u : '0;
  assign u_start = planar ? base_addr + off_u + c_flip : '0;
  assign v_base  = planar ? base_addr + off_v : '0;
  assign v_start = planar ? base_addr + off_v + c_flip : '0;

  logic [DW-1:0] line_cnt;
  logic [SW-1:0] byte_cnt, off_s;
  logic [AW-1:0] y_ls, u_ls, v_ls, ls, addr_c;
  logic [1:0]    plane_c;
  logic          take, chroma_b, emit, byte_last, line_last;

  assign take      = busy & in_valid & ~start;
  assign chroma_b  = planar & ~byte_cnt[0];
  assign emit      = take & ~(chroma_b & line_cnt[0]);
  assign byte_last = byte_cnt == line_bytes - SW'(1);
  assign line_last = line_cnt == height - DW'(1);

  assign plane_c = !chroma_b ? 2'd0 : (byte_cnt[1] ? 2'd2 : 2'd1);
  assign off_s   = !planar ? byte_cnt : (byte_cnt[0] ? byte_cnt >> 1 : byte_cnt >> 2);
  assign ls      = plane_c == 2'd1 ? u_ls : (plane_c == 2'd2 ? v_ls : y_ls);
  assign addr_c  = hflip ? ls - AW'(off_s) : ls + AW'(off_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      line_cnt   <= '0;
      byte_cnt   <= '0;
      y_ls       <= '0;
      u_ls       <= '0;
      v_ls       <= '0;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_plane   <= 2'd0;
      frame_done <= 1'b0;
    end else begin
      wr_valid   <= emit;
      frame_done <= 1'b0;
      if (emit) begin
        wr_addr  <= addr_c;
        wr_plane <= plane_c;
      end
      if (start) begin
        busy     <= 1'b1;
        line_cnt <= '0;
        byte_cnt <= '0;
        y_ls     <= y_start;
        u_ls     <= u_start;
        v_ls     <= v_start;
      end else if (take) begin
        if (!byte_last) begin
          byte_cnt <= byte_cnt + SW'(1);
        end else begin
          byte_cnt <= '0;
          line_cnt <= line_cnt + DW'(1);
          y_ls     <= vflip ? y_ls - sl_a : y_ls + sl_a;
          if (planar && line_cnt[0]) begin
            u_ls <= vflip ? u_ls - cs_a : u_ls + cs_a;
            v_ls <= vflip ? v_ls - cs_a : v_ls + cs_a;
          end
          if (line_last) begin
            busy       <= 1'b0;
            frame_done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/flip_frame_addr_gen_chk.sv
module flip_frame_addr_gen_chk #(
  parameter int AW = 32,
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          planar,
  input logic          hflip,
  input logic          vflip,
  input logic          busy,
  input logic          wr_valid,
  input logic [1:0]    wr_plane,
  input logic          frame_done,
  input logic [DW+1:0] stride_luma,
  input logic [DW+1:0] stride_chroma,
  input logic [AW-1:0] y_base,
  input logic [AW-1:0] y_start
);
  a_r8_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wr_valid);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r5_packed_plane: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !planar) |-> wr_plane == 2'd0);

  a_r7_plane_code: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_plane != 2'd3);

  a_r2_half_stride: assert property (@(posedge clk) disable iff (!rst_n)
    planar |-> {stride_chroma, 1'b0} == {1'b0, stride_luma});

  a_r4_no_flip_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!hflip && !vflip) |-> y_start == y_base);
endmodule

bind flip_frame_addr_gen flip_frame_addr_gen_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .planar(planar),
  .hflip(hflip), .vflip(vflip), .busy(busy), .wr_valid(wr_valid),
  .wr_plane(wr_plane), .frame_done(frame_done), .stride_luma(stride_luma),
  .stride_chroma(stride_chroma), .y_base(y_base), .y_start(y_start)
);

// File: tb/sim_flip_frame_addr_gen.sv
module sim_flip_frame_addr_gen;
  localparam int AW = 32;
  localparam int DW = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [DW-1:0] width = '0, height = '0;
  logic planar = 1'b0, yvu_order = 1'b0, hflip = 1'b0, vflip = 1'b0;
  logic busy, wr_valid, frame_done, chroma_stride_flag;
  logic [AW-1:0] wr_addr, y_base, y_start, u_base, u_start, v_base, v_start;
  logic [1:0] wr_plane;
  logic [DW+1:0] stride_luma, stride_chroma;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  flip_frame_addr_gen #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .width(width), .height(height), .planar(planar), .yvu_order(yvu_order),
    .hflip(hflip), .vflip(vflip), .in_valid(in_valid), .busy(busy),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_plane(wr_plane),
    .frame_done(frame_done), .stride_luma(stride_luma),
    .stride_chroma(stride_chroma), .chroma_stride_flag(chroma_stride_flag),
    .y_base(y_base), .y_start(y_start), .u_base(u_base), .u_start(u_start),
    .v_base(v_base), .v_start(v_start)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ru(input int v, input int m);
    return ((v + m - 1) / m) * m;
  endfunction

  task automatic setup(input int w, input int h, input bit pl, input bit yv,
                       input bit hf, input bit vf, input int base);
    @(negedge clk);
    width = DW'(w); height = DW'(h); planar = pl; yvu_order = yv;
    hflip = hf; vflip = vf; base_addr = AW'(base);
    @(negedge clk);
  endtask

  task automatic expect_byte(input int w, input int h, input bit pl, input bit yv,
                             input bit hf, input bit vf, input int base,
                             input int ln, input int b,
                             output bit ev, output longint ea, output int ep);
    int s, cs, row, crow, uo, vo, j, c;
    s = pl ? ru(w, 8) : ru(w, 2) * 2;
    cs = s / 2;
    row = vf ? h - 1 - ln : ln;
    crow = vf ? h / 2 - 1 - ln / 2 : ln / 2;
    uo = s * h;
    vo = s * h + (s * h) / 4;
    if (yv) begin
      int t;
      t = uo; uo = vo; vo = t;
    end
    ev = 1'b1;
    if (!pl) begin
      ep = 0;
      ea = base + row * s + (hf ? s - 1 - b : b);
    end else if (b % 2 == 1) begin
      j = b / 2;
      ep = 0;
      ea = base + row * s + (hf ? s - 1 - j : j);
    end else begin
      c = b / 4;
      ep = (b % 4 == 0) ? 1 : 2;
      ev = (ln % 2 == 0);
      ea = base + ((ep == 1) ? uo : vo) + crow * cs + (hf ? cs - 1 - c : c);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Streams a whole frame (R5, R6, R7), optional gaps (R8), end (R9)
  task automatic run_frame(input int w, input int h, input bit pl, input bit yv,
                           input bit hf, input bit vf, input int base, input bit gaps);
    int lb;
    bit ev; longint ea; int ep;
    string tag;
    lb = ru(w, 2) * 2;
    tag = pl ? (hf | vf ? "R7/R6" : "R6/R7") : "R5";
    setup(w, h, pl, yv, hf, vf, base);
    pulse_start();
    chk("R10 busy after start", busy, 1);
    for (int ln = 0; ln < h; ln++) begin
      for (int b = 0; b < lb; b++) begin
        if (gaps && (b % 3 == 1)) begin
          in_valid = 1'b0;
          @(negedge clk);
          chk("R8 no write on idle", wr_valid, 0);
        end
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        expect_byte(w, h, pl, yv, hf, vf, base, ln, b, ev, ea, ep);
        chk({tag, " strobe"}, wr_valid, ev);
        if (ev) begin
          chk({tag, " addr"}, wr_addr, ea);
          chk({tag, " plane"}, wr_plane, ep);
        end
      end
    end
    chk("R9 done pulse", frame_done, 1);
    chk("R9 busy low", busy, 0);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 beat after end ignored", wr_valid, 0);
    chk("R9 done single", frame_done, 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic test_reset();
    chk("R11 busy", busy, 0);
    chk("R11 wr_valid", wr_valid, 0);
    chk("R11 frame_done", frame_done, 0);
  endtask

  task automatic test_cfg_packed();
    setup(7, 5, 0, 0, 1, 1, 'h200);
    chk("R1 stride", stride_luma, 16);
    chk("R1 chroma stride", stride_chroma, 0);
    chk("R1 flag", chroma_stride_flag, 0);
    chk("R1 u_base", u_base, 0);
    chk("R1 v_start", v_start, 0);
    chk("R3 y_base", y_base, 'h200);
    chk("R4 y_start", y_start, 'h200 + 16 * 4 + 15);
  endtask

  task automatic test_cfg_planar();
    setup(10, 6, 1, 0, 1, 1, 'h1000);
    chk("R2 stride", stride_luma, 16);
    chk("R2 chroma stride", stride_chroma, 8);
    chk("R2 flag", chroma_stride_flag, 1);
    chk("R3 u_base", u_base, 'h1060);
    chk("R3 v_base", v_base, 'h1078);
    chk("R4 y_start", y_start, 'h105F);
    chk("R4 u_start", u_start, 'h1077);
    chk("R4 v_start", v_start, 'h108F);
    setup(10, 6, 1, 1, 0, 1, 'h1000);
    chk("R3 yvu u_base", u_base, 'h1078);
    chk("R3 yvu v_base", v_base, 'h1060);
    chk("R4 vflip u_start", u_start, 'h1078 + 16);
    setup(10, 6, 1, 0, 1, 0, 'h1000);
    chk("R4 hflip y_start", y_start, 'h100F);
  endtask

  task automatic test_restart();
    setup(6, 4, 0, 0, 0, 0, 'h40);
    pulse_start();
    for (int k = 0; k < 7; k++) begin
      in_valid = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk("R10 busy mid frame", busy, 1);
    @(negedge clk);
    start = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    chk("R10 beat with start ignored", wr_valid, 0);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 restart strobe", wr_valid, 1);
    chk("R10 restart addr", wr_addr, 'h40);
    @(negedge clk);
    run_frame(6, 4, 0, 0, 0, 0, 'h40, 1'b0);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_cfg_packed();
    test_cfg_planar();
    run_frame(6, 3, 0, 0, 0, 0, 'h100, 1'b0);
    run_frame(5, 3, 0, 0, 1, 1, 'h100, 1'b1);
    run_frame(7, 4, 0, 0, 1, 0, 'h300, 1'b0);
    run_frame(6, 4, 1, 0, 0, 0, 'h800, 1'b0);
    run_frame(10, 4, 1, 0, 1, 1, 'h800, 1'b1);
    run_frame(9, 6, 1, 1, 0, 1, 'h2000, 1'b0);
    run_frame(8, 4, 1, 1, 1, 0, 'h2000, 1'b1);
    test_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule